// File: doc/BRIEF.md
# Byte-Stream CRC-16 Engine

This block keeps a running 16-bit checksum over a stream of bytes. It uses the generator 0x1021, shifts each byte in most significant bit first, and applies no output inversion. A byte offered on the manual input port changes the checksum on the next clock edge. A one-cycle init request loads the register with a seed, either all zeros or all ones. A separate combinational path returns any byte with its bit order mirrored.

The block also has a scan sequencer. Give it a starting block number and a count of 256-byte blocks, and it reads that region of memory through a plain read port, one address per cycle. Read data comes back with any latency, marked by a valid strobe, and each returned byte is folded into the same checksum register. While a scan is running the manual byte path and any new scan requests are locked out. A busy level reports the scan, and a one-cycle done pulse marks the moment the last byte has been folded in.

Top module: `crc16_stream`

## Requirements
- R1: After reset `crc_out` is 0x0000, and `scan_busy`, `scan_done` and `mem_rd_en` are all low.
- R2: A cycle with `init_req` high loads `crc_out` at the next edge with 0xFFFF when `seed_ones` is 1 and with 0x0000 when it is 0. In that cycle init takes priority over any byte update.
- R3: While idle, a cycle with `byte_valid` high folds `byte_in` into the checksum. The byte is shifted in MSB first against 0x1021 with no final XOR, and the new value is visible after the next edge. The string "123456789" gives 0x29B1 from seed 0xFFFF and 0x31C3 from seed 0x0000.
- R4: `rev_out[i]` equals `rev_in[7-i]` for every bit, with no clock involved.
- R5: A `scan_start` accepted while idle raises `mem_rd_en` for exactly `scan_count`×256 consecutive cycles, starting the cycle after the start. The addresses run upward by one from `scan_block`×256.
- R6: During a scan, each byte returned with `mem_rd_valid` is folded into the current checksum. The checksum is not re-seeded, so the result equals the checksum of the region in address order, taken from the value the register held before the scan.
- R7: `scan_busy` goes high the cycle after an accepted start. It falls on the edge that folds the last returned byte, and on that same edge `scan_done` rises as a single-cycle pulse. With `scan_count` equal to 0, `scan_done` pulses after the start edge, no read is issued and `scan_busy` stays low.
- R8: While `scan_busy` is high, `byte_valid` and `scan_start` have no effect. The checksum and the address sequence are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_ones | input | 1 | Seed select: 1 gives 0xFFFF, 0 gives 0x0000 |
| init_req | input | 1 | Load the checksum with the selected seed |
| byte_valid | input | 1 | Manual byte strobe |
| byte_in | input | 8 | Manual data byte |
| rev_in | input | 8 | Byte to mirror |
| rev_out | output | 8 | Bit-mirrored `rev_in` |
| scan_start | input | 1 | Start a block scan |
| scan_block | input | ADDR_W-8 | First block number |
| scan_count | input | ADDR_W-7 | Number of blocks to scan |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 8 | Read data |
| crc_out | output | 16 | Current checksum |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Pulse when a scan completes |

## Verification
Every byte changes the checksum through a chain of feedback, so a wrong update term, a skipped byte or a swapped address shows up at once. After a single update the 16-bit result at `crc_out` differs, and the error then carries through to every later value. A sequencer that issues one read too many or too few, or stops early, produces a different final checksum. It also moves the done pulse away from the exact edge that follows read count plus memory latency. A busy flag that drops too early lets a manual byte corrupt the result before the scan ends.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BLK_SH   = 8;

  function automatic logic [15:0] crc_fold(input logic [15:0] cur, input logic [7:0] d);
    logic [15:0] c;
    logic        fb;
    c = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc16_bitrev.sv
module crc16_bitrev #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_mirror
    assign dout[g] = din[W-1-g];
  end
endmodule

// File: rtl/crc16_core.sv
module crc16_core
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_ones,
  input  logic        init_req,
  input  logic        upd_en,
  input  logic [7:0]  upd_byte,
  output logic [15:0] crc_q
);
  logic [15:0] crc_d;
  logic        crc_en;

  always_comb begin
    crc_en = init_req | upd_en;
    crc_d  = crc_q;
    if (init_req)    crc_d = seed_ones ? 16'hFFFF : 16'h0000;
    else if (upd_en) crc_d = crc_fold(crc_q, upd_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/crc16_scan.sv
module crc16_scan
  import crc16_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-9:0]     blk,
  input  logic [ADDR_W-8:0]     cnt,
  input  logic                  rd_valid,
  output logic                  rd_en,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic                  busy,
  output logic                  done,
  output logic                  take
);
  localparam int unsigned CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0]  issue_q, issue_d;
  logic [CNT_W-1:0]  recv_q,  recv_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic              done_q,  done_d;
  logic              accept;

  assign rd_en   = (issue_q != '0);
  assign busy    = (recv_q != '0);
  assign take    = busy & rd_valid;
  assign rd_addr = addr_q;
  assign done    = done_q;
  assign accept  = start & ~busy;

  always_comb begin
    issue_d = issue_q;
    recv_d  = recv_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    if (accept) begin
      issue_d = {cnt, {BLK_SH{1'b0}}};
      recv_d  = {cnt, {BLK_SH{1'b0}}};
      addr_d  = {blk, {BLK_SH{1'b0}}};
      done_d  = (cnt == '0);
    end else begin
      if (rd_en) begin
        issue_d = issue_q - 1'b1;
        addr_d  = addr_q + 1'b1;
      end
      if (take) begin
        recv_d = recv_q - 1'b1;
        done_d = (recv_q == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= '0;
      recv_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      issue_q <= issue_d;
      recv_q  <= recv_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/crc16_stream.sv
module crc16_stream #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_ones,
  input  logic              init_req,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  input  logic [7:0]        rev_in,
  output logic [7:0]        rev_out,
  input  logic              scan_start,
  input  logic [ADDR_W-9:0] scan_block,
  input  logic [ADDR_W-8:0] scan_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd_valid,
  input  logic [7:0]        mem_rd_data,
  output logic [15:0]       crc_out,
  output logic              scan_busy,
  output logic              scan_done
);
  logic       take;
  logic       upd_en;
  logic [7:0] upd_byte;

  crc16_bitrev #(.W(8)) u_rev (.din(rev_in), .dout(rev_out));

  crc16_scan #(.ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(scan_start), .blk(scan_block),
    .cnt(scan_count), .rd_valid(mem_rd_valid), .rd_en(mem_rd_en),
    .rd_addr(mem_addr), .busy(scan_busy), .done(scan_done), .take(take)
  );

  always_comb begin
    upd_en   = scan_busy ? take : byte_valid;
    upd_byte = scan_busy ? mem_rd_data : byte_in;
  end

  crc16_core u_core (
    .clk(clk), .rst_n(rst_n), .seed_ones(seed_ones), .init_req(init_req),
    .upd_en(upd_en), .upd_byte(upd_byte), .crc_q(crc_out)
  );
endmodule

// File: rtl/crc16_stream_chk.sv
module crc16_stream_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_ones,
  input logic              init_req,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_valid,
  input logic [15:0]       crc_out,
  input logic              scan_busy,
  input logic              scan_done
);
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> crc_out == ($past(seed_ones) ? 16'hFFFF : 16'h0000));

  a_r5_read_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> scan_busy);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_addr == $past(mem_addr) + 1'b1);

  a_r7_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_busy) |-> scan_done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !scan_busy);

  a_r8_hold_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_busy && !mem_rd_valid && !init_req) |=> $stable(crc_out));
endmodule

bind crc16_stream crc16_stream_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_ones(seed_ones), .init_req(init_req),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
  .crc_out(crc_out), .scan_busy(scan_busy), .scan_done(scan_done)
);

// File: tb/crc16_stream_bench.sv
module crc16_stream_bench;
  localparam int unsigned ADDR_W = 16;

  logic              clk, rst_n;
  logic              seed_ones, init_req, byte_valid, scan_start;
  logic [7:0]        byte_in, rev_in, rev_out, mem_rd_data;
  logic [ADDR_W-9:0] scan_block;
  logic [ADDR_W-8:0] scan_count;
  logic              mem_rd_en, mem_rd_valid, scan_busy, scan_done;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0]       crc_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  typedef struct { string req; logic [15:0] exp; } sb_item_t;
  sb_item_t sb_q[$];
  logic [15:0] model;

  crc16_stream #(.ADDR_W(ADDR_W)) u_crc16_stream (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory model, two cycles from request to data
  logic              p1_v;
  logic [ADDR_W-1:0] p1_a;
  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ (a[15:8] * 8'd37) ^ 8'h5A;
  endfunction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p1_a <= '0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
    end else begin
      p1_v <= mem_rd_en; p1_a <= mem_addr;
      mem_rd_valid <= p1_v; mem_rd_data <= mem_byte(p1_a);
    end
  end

  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares the checksum at each falling edge with the queued expectation
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(it.req, crc_out, it.exp);
    end
  end

  task automatic push_exp(input string req);
    sb_item_t it;
    it.req = req; it.exp = model;
    sb_q.push_back(it);
  endtask

  task automatic do_init(input logic ones, input logic also_byte);
    @(negedge clk);
    seed_ones = ones; init_req = 1'b1; byte_valid = also_byte; byte_in = 8'hA5;
    @(negedge clk);
    init_req = 1'b0; byte_valid = 1'b0;
    model = ones ? 16'hFFFF : 16'h0000;
    @(posedge clk); #1 push_exp("R2");
  endtask

  task automatic feed_string;
    string s;
    s = "123456789";
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_in = s[i];
      model = ref_fold(model, s[i]);
    end
    @(negedge clk); byte_valid = 1'b0;
    @(posedge clk); #1 push_exp("R3");
  endtask

  task automatic run_scan(input logic [ADDR_W-9:0] blk, input logic [ADDR_W-8:0] cnt);
    int m, n, reads, done_at, busy_first;
    logic [ADDR_W-1:0] a;
    m = int'(cnt) * 256;
    @(negedge clk);
    scan_block = blk; scan_count = cnt; scan_start = 1'b1;
    @(posedge clk);
    n = 0; reads = 0; done_at = -1; busy_first = -1;
    @(negedge clk);
    scan_start = 1'b0;
    while (done_at < 0 && n < m + 20) begin
      n++;
      if (mem_rd_en) reads++;
      if (scan_busy && busy_first < 0) busy_first = n;
      if (scan_done) done_at = n;
      // R8: manual bytes and new starts during the scan must have no effect
      byte_valid = scan_busy; byte_in = 8'hC3;
      scan_start = scan_busy; scan_block = '1; scan_count = 1;
      @(negedge clk);
    end
    byte_valid = 1'b0; scan_start = 1'b0;
    a = {blk, 8'h00};
    for (int i = 0; i < m; i++) begin
      model = ref_fold(model, mem_byte(a));
      a = a + 1'b1;
    end
    check("R5 read count", reads, m);
    check("R7 done edge", done_at, (m == 0) ? 1 : m + 3);
    check("R7 busy start", busy_first, (m == 0) ? -1 : 1);
    check("R7 busy after done", scan_busy, 0);
    #1 push_exp("R6 R8 scan checksum");
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; seed_ones = 1'b0; init_req = 1'b0; byte_valid = 1'b0;
    byte_in = '0; rev_in = '0; scan_start = 1'b0; scan_block = '0; scan_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 crc", crc_out, 16'h0000);
    check("R1 busy", scan_busy, 0);
    check("R1 done", scan_done, 0);
    check("R1 rd_en", mem_rd_en, 0);

    rev_in = 8'b1100_1010; #1 check("R4 mirror a", rev_out, 8'b0101_0011);
    rev_in = 8'h01;        #1 check("R4 mirror b", rev_out, 8'h80);

    do_init(1'b1, 1'b1);
    feed_string();
    @(negedge clk); check("R3 ones check value", crc_out, 16'h29B1);
    do_init(1'b0, 1'b0);
    feed_string();
    @(negedge clk); check("R3 zero check value", crc_out, 16'h31C3);

    do_init(1'b1, 1'b0);
    run_scan(8'h03, 9'd1);
    do_init(1'b0, 1'b0);
    run_scan(8'h10, 9'd2);
    run_scan(8'hFF, 9'd0);
    do_init(1'b1, 1'b0);
    run_scan(8'h40, 9'd3);

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule